// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a computer-operating-properly watchdog that sits on a simple register write bus. A free-running counter advances on every clock. If it reaches the end of its period, the block emits a one-cycle timeout pulse, which the reset sequencer takes as a reset request. Software keeps the counter from expiring by writing a two-step key to one service address: first 55h, then AAh. Only this ordered pair restarts the counter. A lone AAh does nothing, and neither does a write to any other address.

A 2-bit rate input selects one of four periods, spaced by a factor of four. The block captures this input only during a short protected window after reset, so a later change to it has no effect. A disable input holds the counter at zero and stops all timeouts. Both the base period exponent and the window length are parameters. By default the periods are 2^15, 2^17, 2^19 and 2^21 cycles and the window is 64 cycles.

Top module: `kwdt_top`

## Requirements
- R1: While `rst` is high, `wdog_bite` is low and the counter is zero. With the watchdog enabled and no servicing, the first timeout pulse appears exactly P clock edges after the first edge with `rst` low.
- R2: The period P is 2^(BASE_LOG2 + RATE_STEP*r), where r is the captured rate value 0 to 3. With the defaults, the periods are 2^15, 2^17, 2^19 and 2^21 cycles.
- R3: `wdog_bite` is high for exactly one cycle. After a timeout, the counter restarts from zero and the next pulse follows P edges after the previous one.
- R4: A write of 55h to address SVC_ADDR, followed by a write of AAh to the same address, clears the counter on the edge that takes the AAh write. The next timeout then comes P edges after that edge.
- R5: A write of AAh to SVC_ADDR when no 55h is pending does not clear the counter.
- R6: After 55h has been written, writes of other values (including 55h again) keep the sequence armed, and a later AAh still services the counter.
- R7: The servicing AAh write disarms the sequence, so a further AAh alone does not clear the counter.
- R8: Writes to any address other than SVC_ADDR change neither the counter nor the armed state.
- R9: While `wdog_off` is high, the counter is held at zero and no timeout pulse is produced. Once `wdog_off` goes low, counting starts again from zero.
- R10: `rate_sel` is captured on every edge during the first WIN_CYCLES edges after reset. After that window, changes to `rate_sel` are ignored until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | AW | Write address |
| bus_wdata | input | 8 | Write data |
| rate_sel | input | 2 | Period select, captured during the protected window |
| wdog_off | input | 1 | High disables the watchdog |
| wdog_bite | output | 1 | One-cycle timeout pulse, registered |

## Verification
On every cycle, the assertions check that the pulse lasts one cycle and the counter wraps to zero with it, that the disable input suppresses the pulse, that a service clears the counter and disarms the key, that writes elsewhere leave the armed state alone, and that the captured rate cannot move once the window has closed. Only the bench scenarios can show the exact period for each rate and how many cycles remain after an ignored write. They also cover the effect of an out-of-order key and of a rate change before and after the window closes. The bench does this by timing the pulse from a known edge.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int NUM_RATES = 4;
  localparam int RATE_W = 2;
endpackage

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SVC_ADDR = 8'h3A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          kick,
  output logic          armed
);
  import kwdt_pkg::*;

  logic hit, arm_w, fire_w;

  always_comb begin
    hit    = we && (addr == SVC_ADDR);
    arm_w  = hit && (wdata == KEY_ARM);
    fire_w = hit && (wdata == KEY_FIRE) && armed;
  end

  always_ff @(posedge clk) begin
    if (rst)         armed <= 1'b0;
    else if (fire_w) armed <= 1'b0;
    else if (arm_w)  armed <= 1'b1;
  end

  assign kick = fire_w;

  // R6: a first key write arms the sequence
  assert_arm_on_key_R6: assert property (@(posedge clk) disable iff (rst)
    arm_w |=> armed);
  // R7: a service disarms the sequence
  assert_fire_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    kick |=> !armed);
  // R8: writes to other addresses leave the armed state alone
  assert_other_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (we && addr != SVC_ADDR) |=> $stable(armed));
endmodule

// File: rtl/kwdt_rate_win.sv
module kwdt_rate_win #(
  parameter int WIN_CYCLES = 64,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rate_in,
  output logic [RW-1:0] rate_q,
  output logic          win_open
);
  localparam int WCW = $clog2(WIN_CYCLES + 1);

  logic [WCW-1:0] win_cnt;

  assign win_open = (win_cnt < WCW'(WIN_CYCLES));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      rate_q  <= rate_in;
    end else if (win_open) begin
      win_cnt <= win_cnt + 1'b1;
      rate_q  <= rate_in;
    end
  end

  // R10: captured rate is frozen once the window has closed
  assert_rate_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(rate_q));
  // R10: the window never reopens without reset
  assert_window_stays_shut_R10: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> !win_open);
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
  parameter int BASE_LOG2 = 15,
  parameter int RATE_STEP = 2,
  parameter int RW = 2,
  parameter int NUM_RATES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          off,
  input  logic          kick,
  input  logic [RW-1:0] rate,
  output logic          bite
);
  localparam int MAX_EXP = BASE_LOG2 + RATE_STEP * (NUM_RATES - 1);
  localparam int CW = MAX_EXP + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  int            sh;

  always_comb begin
    sh    = BASE_LOG2 + RATE_STEP * int'(rate);
    limit = (CW'(1) << sh) - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bite <= 1'b0;
    end else if (off || kick) begin
      cnt  <= '0;
      bite <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      bite <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      bite <= 1'b0;
    end
  end

  // R1: reset leaves a cleared counter and a quiet output
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cnt == '0 && !bite));
  // R3: pulse is a single cycle
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    bite |=> !bite);
  // R3: counter wraps to zero with the pulse
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    bite |-> cnt == '0);
  // R4: service clears the counter
  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0 && !bite));
  // R9: disabled watchdog never bites
  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    off |=> (!bite && cnt == '0));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int AW = 8,
  parameter logic [AW-1:0] SVC_ADDR = 8'h3A,
  parameter int BASE_LOG2 = 15,
  parameter int RATE_STEP = 2,
  parameter int WIN_CYCLES = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic [1:0]    rate_sel,
  input  logic          wdog_off,
  output logic          wdog_bite
);
  import kwdt_pkg::*;

  logic              kick, armed, win_open;
  logic [RATE_W-1:0] rate_q;

  kwdt_key_seq #(.AW(AW), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .kick(kick), .armed(armed)
  );

  kwdt_rate_win #(.WIN_CYCLES(WIN_CYCLES), .RW(RATE_W)) u_rate (
    .clk(clk), .rst(rst), .rate_in(rate_sel), .rate_q(rate_q), .win_open(win_open)
  );

  kwdt_count #(.BASE_LOG2(BASE_LOG2), .RATE_STEP(RATE_STEP), .RW(RATE_W),
               .NUM_RATES(NUM_RATES)) u_cnt (
    .clk(clk), .rst(rst), .off(wdog_off), .kick(kick), .rate(rate_q), .bite(wdog_bite)
  );

  // R5: a service can only happen from the armed state
  assert_kick_needs_arm_R5: assert property (@(posedge clk) disable iff (rst)
    kick |-> armed);
endmodule

// File: tb/sim_kwdt_top.sv
`timescale 1ns/1ps
module sim_kwdt_top;
  localparam int BASE = 4;
  localparam int WIN = 8;
  localparam logic [7:0] SVC = 8'h3A;
  localparam logic [7:0] OTHER = 8'h3B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] rate_sel = 2'd0;
  logic       wdog_off = 1'b0;
  logic       wdog_bite;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kwdt_top #(.AW(8), .SVC_ADDR(SVC), .BASE_LOG2(BASE), .RATE_STEP(2),
             .WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rate_sel(rate_sel), .wdog_off(wdog_off),
    .wdog_bite(wdog_bite)
  );

  function automatic int per(int r);
    return 1 << (BASE + 2 * r);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(2);
    chk(wdog_bite == 1'b0, "R1 bite low in reset", wdog_bite, 0);
    rst = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic measure(int exp, string tag);
    int n = 0;
    bit seen = 0;
    while (!seen && n < 5000) begin
      @(posedge clk); #1;
      n++;
      if (wdog_bite) seen = 1;
    end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic t_reset();
    rate_sel = 2'd0; wdog_off = 1'b0;
    do_reset();
    measure(per(0), "R1 first timeout after reset");
  endtask

  task automatic t_rates();
    for (int r = 1; r < 4; r++) begin
      rate_sel = 2'(r);
      do_reset();
      measure(per(r), "R2 period for rate value");
    end
  endtask

  task automatic t_repeat();
    rate_sel = 2'd0;
    do_reset();
    measure(per(0), "R3 first pulse");
    idle(1);
    chk(wdog_bite == 1'b0, "R3 pulse one cycle", wdog_bite, 0);
    measure(per(0) - 1, "R3 next pulse after one period");
  endtask

  task automatic t_service();
    rate_sel = 2'd0;
    do_reset();
    idle(10);
    wr(SVC, 8'h55);
    wr(SVC, 8'hAA);
    measure(per(0), "R4 key pair restarts counter");
  endtask

  task automatic t_lone_fire();
    rate_sel = 2'd0;
    do_reset();
    idle(10);
    wr(SVC, 8'hAA);
    measure(per(0) - 11, "R5 lone AAh ignored");
  endtask

  task automatic t_armed_other();
    rate_sel = 2'd0;
    do_reset();
    idle(5);
    wr(SVC, 8'h55);
    wr(SVC, 8'h12);
    wr(SVC, 8'h55);
    wr(SVC, 8'h00);
    wr(SVC, 8'hAA);
    measure(per(0), "R6 stays armed through other values");
  endtask

  task automatic t_disarm();
    rate_sel = 2'd0;
    do_reset();
    wr(SVC, 8'h55);
    wr(SVC, 8'hAA);
    idle(4);
    wr(SVC, 8'hAA);
    measure(per(0) - 5, "R7 second AAh after service ignored");
  endtask

  task automatic t_other_addr();
    rate_sel = 2'd0;
    do_reset();
    wr(OTHER, 8'h55);
    wr(SVC, 8'hAA);
    measure(per(0) - 2, "R8 arm at other address ignored");
    do_reset();
    wr(SVC, 8'h55);
    wr(OTHER, 8'hAA);
    measure(per(0) - 2, "R8 fire at other address ignored");
  endtask

  task automatic t_disable();
    int highs = 0;
    rate_sel = 2'd0;
    do_reset();
    wdog_off = 1'b1;
    for (int i = 0; i < 3 * per(0); i++) begin
      @(posedge clk); #1;
      if (wdog_bite) highs++;
    end
    chk(highs == 0, "R9 no pulse while disabled", highs, 0);
    wdog_off = 1'b0;
    measure(per(0), "R9 count from zero after enable");
  endtask

  task automatic t_window();
    rate_sel = 2'd0;
    do_reset();
    idle(WIN + 4);
    rate_sel = 2'd3;
    measure(per(0) - (WIN + 4), "R10 late rate change ignored");
    rate_sel = 2'd0;
    do_reset();
    idle(2);
    rate_sel = 2'd1;
    measure(per(1) - 2, "R10 rate change inside window taken");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rates();
    t_repeat();
    t_service();
    t_lone_fire();
    t_armed_other();
    t_disarm();
    t_other_addr();
    t_disable();
    t_window();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule